// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block gathers 72 level-sensitive interrupt sources into two output lines. There is a 64-source peripheral bank and an 8-source basic bank. Software reaches the block through a small word-addressed register port. The enable masks are never written as a whole. They change only through write-one-to-set and write-one-to-clear words, so one agent can enable or disable a source without a read-modify-write that might undo another agent's change.

A 7-bit selector together with an enable flag steers any single source to the fast interrupt line. While that route is enabled, the chosen source is taken out of the normal IRQ. Software can read the raw level of every source through three pending words. Both outputs are combinational functions of the registered state and the live source levels. A register write therefore shows up on the outputs in the cycle after the clock edge that captures it.

Word map, with `addr` as a word index:

| addr | name | access |
|------|------|--------|
| 0 | basic pending | R |
| 1 | peripheral pending, sources 31:0 | R |
| 2 | peripheral pending, sources 63:32 | R |
| 3 | fast route control | R/W |
| 4 | peripheral set, low half | R/W |
| 5 | peripheral set, high half | R/W |
| 6 | basic set | R/W |
| 7 | peripheral clear, low half | R/W |
| 8 | peripheral clear, high half | R/W |
| 9 | basic clear | R/W |

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, both enable masks, the fast route selector and the fast route enable are all zero. Both outputs are low, and every readable word returns zero while all sources are low.
- R2: A write to word 3 loads the selector from bits 6:0 and the fast route enable from bit 7. Reading word 3 returns {24'b0, enable, selector}.
- R3: A write to word 4 ORs the written word into peripheral enable bits 31:0. A write to word 5 ORs it into bits 63:32. Reading word 4 or word 5 returns the current low or high mask half.
- R4: A write to word 7 clears peripheral enable bits 31:0 wherever the written word has a 1. A write to word 8 does the same for bits 63:32. Reading word 7 or word 8 returns the current low or high mask half.
- R5: A write to word 6 ORs bits 7:0 of the written word into the 8-bit basic enable mask. A write to word 9 clears the mask bits where bits 7:0 are 1. Bits 31:8 are ignored by both. Reading word 6 or word 9 returns the mask in bits 7:0.
- R6: Reading word 0 returns the basic source levels in bits 7:0. Reading word 1 returns peripheral sources 31:0, and reading word 2 returns sources 63:32. Writes to words 0 to 2 change no state.
- R7: Writes to words 10 to 15 change no state. Reads of words 10 to 15 return zero.
- R8: `irq` is high exactly when some source is high, its enable bit is set, and it is not the source currently routed to the fast line. A write that changes a mask is reflected on `irq` in the cycle after its clock edge.
- R9: `fiq` is high exactly when the fast route enable is set and the selected source is high, whatever its enable bit holds. Selector values 0 to 63 pick peripheral sources 0 to 63. Values 64 to 71 pick basic sources 0 to 7. Values 72 to 127 pick nothing.
- R10: While the fast route enable is clear, the selected source takes part in `irq` like any other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Word index of the register access |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| periph_src | input | 64 | Peripheral bank source levels |
| basic_src | input | 8 | Basic bank source levels |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench sweeps the selector through all 128 values. This exposes a decoder that wraps values above 71 onto real sources, or that maps the basic bank off by one. It also walks a single enable bit across all 72 sources while every other source is driven high, which catches a crossed or shifted mask bit. Set and clear writes are layered over bits that are already set, so a design that loads the mask directly instead of ORing or masking leaves the wrong readback. Writes to the pending words and to the six unused words are followed by readback of every mask, since a loose decoder would corrupt state there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int BASIC_N  = 8;
    localparam int PERIPH_N = 2 * DATA_W;
    localparam int TOTAL_N  = PERIPH_N + BASIC_N;
    localparam int SEL_W    = $clog2(TOTAL_N);

    localparam logic [ADDR_W-1:0] OFF_PEND_B  = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_PEND_LO = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_PEND_HI = 4'd2;
    localparam logic [ADDR_W-1:0] OFF_ROUTE   = 4'd3;
    localparam logic [ADDR_W-1:0] OFF_SET_LO  = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_SET_HI  = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_SET_B   = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_CLR_LO  = 4'd7;
    localparam logic [ADDR_W-1:0] OFF_CLR_HI  = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_CLR_B   = 4'd9;

    typedef struct packed {
        logic [PERIPH_N-1:0] pen;
        logic [BASIC_N-1:0]  ben;
        logic [SEL_W-1:0]    sel;
        logic                fen;
    } irqc_state_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output irqc_state_t       state
);
    localparam int HI_TOP = PERIPH_N - 1;

    irqc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                OFF_ROUTE: begin
                    st_d.sel = wr_data[SEL_W-1:0];
                    st_d.fen = wr_data[SEL_W];
                end
                OFF_SET_LO: st_d.pen[DATA_W-1:0]      = st_q.pen[DATA_W-1:0] | wr_data;
                OFF_SET_HI: st_d.pen[HI_TOP:DATA_W]   = st_q.pen[HI_TOP:DATA_W] | wr_data;
                OFF_SET_B:  st_d.ben                  = st_q.ben | wr_data[BASIC_N-1:0];
                OFF_CLR_LO: st_d.pen[DATA_W-1:0]      = st_q.pen[DATA_W-1:0] & ~wr_data;
                OFF_CLR_HI: st_d.pen[HI_TOP:DATA_W]   = st_q.pen[HI_TOP:DATA_W] & ~wr_data;
                OFF_CLR_B:  st_d.ben                  = st_q.ben & ~wr_data[BASIC_N-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
(
    input  irqc_state_t         state,
    input  logic [PERIPH_N-1:0] periph_src,
    input  logic [BASIC_N-1:0]  basic_src,
    output logic                irq,
    output logic                fiq
);
    logic [TOTAL_N-1:0] all_src;
    logic [TOTAL_N-1:0] all_en;
    logic [TOTAL_N-1:0] hot;
    logic [TOTAL_N-1:0] norm_hit;
    logic [TOTAL_N-1:0] fast_hit;

    assign all_src = {basic_src, periph_src};
    assign all_en  = {state.ben, state.pen};

    for (genvar g = 0; g < TOTAL_N; g++) begin : g_src
        assign hot[g]      = state.fen && (state.sel == SEL_W'(g));
        assign norm_hit[g] = all_src[g] && all_en[g] && !hot[g];
        assign fast_hit[g] = all_src[g] && hot[g];
    end

    assign irq = |norm_hit;
    assign fiq = |fast_hit;
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  irqc_state_t         state,
    input  logic [PERIPH_N-1:0] periph_src,
    input  logic [BASIC_N-1:0]  basic_src,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int HI_TOP = PERIPH_N - 1;

    always_comb begin
        rd_data = '0;
        case (addr)
            OFF_PEND_B:              rd_data = DATA_W'(basic_src);
            OFF_PEND_LO:             rd_data = periph_src[DATA_W-1:0];
            OFF_PEND_HI:             rd_data = periph_src[HI_TOP:DATA_W];
            OFF_ROUTE:               rd_data = DATA_W'({state.fen, state.sel});
            OFF_SET_LO, OFF_CLR_LO:  rd_data = state.pen[DATA_W-1:0];
            OFF_SET_HI, OFF_CLR_HI:  rd_data = state.pen[HI_TOP:DATA_W];
            OFF_SET_B, OFF_CLR_B:    rd_data = DATA_W'(state.ben);
            default:                 rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [PERIPH_N-1:0] periph_src,
    input  logic [BASIC_N-1:0]  basic_src,
    output logic                irq,
    output logic                fiq
);
    irqc_state_t state;

    irqc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .state   (state)
    );

    irqc_route u_route (
        .state      (state),
        .periph_src (periph_src),
        .basic_src  (basic_src),
        .irq        (irq),
        .fiq        (fiq)
    );

    irqc_rdmux u_rdmux (
        .addr       (addr),
        .state      (state),
        .periph_src (periph_src),
        .basic_src  (basic_src),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [PERIPH_N-1:0] pen,
    input logic [BASIC_N-1:0]  ben,
    input logic [SEL_W-1:0]    sel,
    input logic                fen,
    input logic                irq,
    input logic                fiq
);
    localparam int HI_TOP = PERIPH_N - 1;

    assert_route_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_ROUTE) |=> (sel == $past(wr_data[SEL_W-1:0]) && fen == $past(wr_data[SEL_W])));

    assert_set_lo_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SET_LO) |=>
        ((pen[DATA_W-1:0] & ($past(wr_data) | $past(pen[DATA_W-1:0]))) == ($past(wr_data) | $past(pen[DATA_W-1:0]))));

    assert_clr_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR_HI) |=> ((pen[HI_TOP:DATA_W] & $past(wr_data)) == '0));

    assert_clr_basic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR_B) |=> ((ben & $past(wr_data[BASIC_N-1:0])) == '0));

    assert_unused_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > OFF_CLR_B) |=> ($stable(pen) && $stable(ben) && $stable(sel) && $stable(fen)));

    assert_pending_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < OFF_ROUTE) |=> ($stable(pen) && $stable(ben) && $stable(sel) && $stable(fen)));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pen) && $stable(ben) && $stable(sel) && $stable(fen)));

    assert_no_mask_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pen == '0 && ben == '0) |-> !irq);

    assert_fast_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fen |-> !fiq);

    assert_fast_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= SEL_W'(TOTAL_N)) |-> !fiq);
endmodule

bind irq_bank_ctrl irqc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .pen     (state.pen),
    .ben     (state.ben),
    .sel     (state.sel),
    .fen     (state.fen),
    .irq     (irq),
    .fiq     (fiq)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  addr = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic [63:0] periph_src = 0;
    logic [7:0]  basic_src = 0;
    logic        irq, fiq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] m_pen = 0;
    logic [7:0]  m_ben = 0;
    logic [6:0]  m_sel = 0;
    logic        m_fen = 0;
    logic [31:0] lf = 32'hACE1_1234;

    irq_bank_ctrl u_irq_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .periph_src(periph_src), .basic_src(basic_src),
        .irq(irq), .fiq(fiq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        case (a)
            4'd3: begin m_sel = d[6:0]; m_fen = d[7]; end
            4'd4: m_pen[31:0]  = m_pen[31:0] | d;
            4'd5: m_pen[63:32] = m_pen[63:32] | d;
            4'd6: m_ben = m_ben | d[7:0];
            4'd7: m_pen[31:0]  = m_pen[31:0] & ~d;
            4'd8: m_pen[63:32] = m_pen[63:32] & ~d;
            4'd9: m_ben = m_ben & ~d[7:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, 72'(rd_data), 72'(exp));
    endtask

    task automatic drive(input logic [71:0] s);
        periph_src = s[63:0];
        basic_src  = s[71:64];
        #1;
    endtask

    function automatic logic exp_irq(input logic [71:0] s);
        logic [71:0] hot = '0;
        if (m_fen && m_sel < 7'd72) hot[m_sel] = 1'b1;
        return |(s & {m_ben, m_pen} & ~hot);
    endfunction

    function automatic logic exp_fiq(input logic [71:0] s);
        return m_fen && (m_sel < 7'd72) && s[m_sel];
    endfunction

    task automatic chk_out(input logic [71:0] s, input string tag);
        drive(s);
        chk({tag, " irq"}, 72'(irq), 72'(exp_irq(s)));
        chk({tag, " fiq"}, 72'(fiq), 72'(exp_fiq(s)));
    endtask

    task automatic chk_masks(input string tag);
        rd(4'd4, m_pen[31:0], tag);
        rd(4'd5, m_pen[63:32], tag);
        rd(4'd7, m_pen[31:0], tag);
        rd(4'd8, m_pen[63:32], tag);
        rd(4'd6, {24'b0, m_ben}, tag);
        rd(4'd9, {24'b0, m_ben}, tag);
        rd(4'd3, {24'b0, m_fen, m_sel}, tag);
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R1 reset read");
        chk("R1 reset irq", 72'(irq), 72'd0);
        chk("R1 reset fiq", 72'(fiq), 72'd0);

        // R2: route control load and readback
        wr(4'd3, 32'hFFFF_FF85);
        rd(4'd3, 32'h0000_0085, "R2 route readback");
        wr(4'd3, 32'h0000_0047);
        rd(4'd3, 32'h0000_0047, "R2 route readback");
        wr(4'd3, 32'h0);

        // R3 / R4: set and clear layered
        wr(4'd4, 32'hA5A5_0F0F); chk_masks("R3 set lo");
        wr(4'd5, 32'h1234_5678); chk_masks("R3 set hi");
        wr(4'd4, 32'h0000_F000); chk_masks("R3 set lo or");
        wr(4'd7, 32'h0F00_0101); chk_masks("R4 clr lo");
        wr(4'd8, 32'hFFFF_0000); chk_masks("R4 clr hi");
        wr(4'd5, 32'h8000_0001); chk_masks("R3 set hi or");
        wr(4'd7, 32'h0);         chk_masks("R4 clr lo zero");

        // R5: basic bank, upper bits ignored
        wr(4'd6, 32'hFFFF_FF3C); chk_masks("R5 set basic");
        rd(4'd6, 32'h0000_003C, "R5 basic value");
        wr(4'd9, 32'hFFFF_FE04); chk_masks("R5 clr basic");
        rd(4'd9, 32'h0000_0038, "R5 basic value");

        // R6: pending words and writes to them
        drive({8'h5A, 64'hDEAD_BEEF_0123_4567});
        rd(4'd0, 32'h0000_005A, "R6 pend basic");
        rd(4'd1, 32'h0123_4567, "R6 pend lo");
        rd(4'd2, 32'hDEAD_BEEF, "R6 pend hi");
        for (int a = 0; a < 3; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            chk_masks("R6 pend write ignored");
        end
        drive(72'h0);

        // R7: unused words
        for (int a = 10; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            chk_masks("R7 unused write ignored");
            rd(4'(a), 32'h0, "R7 unused read");
        end

        // R8: single enable walk over all sources
        wr(4'd7, 32'hFFFF_FFFF); wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFF);
        for (int i = 0; i < 72; i++) begin
            logic [71:0] one;
            one = 72'd1 << i;
            if (i < 32) wr(4'd4, 32'd1 << i);
            else if (i < 64) wr(4'd5, 32'd1 << (i - 32));
            else wr(4'd6, 32'd1 << (i - 64));
            drive(~one);
            chk("R8 others high irq", 72'(irq), 72'd0);
            drive(one);
            chk("R8 own high irq", 72'(irq), 72'd1);
            if (i < 32) wr(4'd7, 32'd1 << i);
            else if (i < 64) wr(4'd8, 32'd1 << (i - 32));
            else wr(4'd9, 32'd1 << (i - 64));
            chk("R8 after clear irq", 72'(irq), 72'd0);
        end

        // R8: mixed masks and sources
        for (int k = 0; k < 40; k++) begin
            logic [71:0] s;
            step_lf(); wr(4'd4, lf & 32'h0F0F_0F0F);
            step_lf(); wr(4'd8, lf);
            step_lf(); wr(4'd6, lf);
            step_lf(); s[31:0] = lf & {lf[15:0], lf[31:16]};
            step_lf(); s[63:32] = lf & {lf[7:0], lf[31:8]};
            step_lf(); s[71:64] = lf[7:0] & lf[15:8];
            chk_out(s, "R8 mixed");
        end
        drive(72'h0);

        // R9 / R10: full selector sweep with all enables set
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF); wr(4'd6, 32'hFF);
        for (int s = 0; s < 128; s++) begin
            logic [71:0] one;
            one = (s < 72) ? (72'd1 << s) : 72'd0;
            wr(4'd3, 32'h80 | 32'(s));
            chk_out(one, "R9 routed only");
            if (s < 72) chk("R9 routed only fiq high", 72'(fiq), 72'd1);
            chk_out({72{1'b1}}, "R9 all high");
            chk_out(~one, "R9 all but routed");
            wr(4'd3, 32'(s));
            chk_out(one, "R10 route disabled");
            if (s < 72) chk("R10 selected joins irq", 72'(irq), 72'd1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule